// File: doc/BRIEF.md
# Frequent Loop Profiler

This block sits beside a processor's instruction fetch path and only listens to it. It has no output that can hold or alter a fetch. Each fetch cycle it looks at the fetch strobe, the fetch address and the taken-branch flag with its target. A taken branch whose target is strictly below the branch's own address counts as one pass around a loop. That loop is named by the pair (target, branch address), called head and tail here.

The loops go into a small fully associative table of sixteen slots. Each slot has a saturating pass counter. When a counter is about to reach its ceiling, every counter in the table is halved in the same cycle. The counts therefore keep the ratios between loops rather than absolute totals. When a new loop arrives and no slot is free, it takes the slot with the smallest count.

A partitioning controller reads the table one slot at a time through an indexed readout port. A synchronous clear input empties the table.

Top module: `lp_profiler`

## Requirements
- R1: When `fetch_valid` and `br_taken` are both high and `br_target` is strictly less than `fetch_addr`, a loop with head=`br_target` and tail=`fetch_addr` is recorded. If no slot holds that loop, it goes into the lowest-indexed unused slot with a count of 1.
- R2: No slot changes when `fetch_valid` is low, when `br_taken` is low, or when `br_target` is greater than or equal to `fetch_addr`.
- R3: When a recorded loop is seen again, the count of its slot rises by exactly 1.
- R4: When a new loop arrives and all slots are in use, it replaces the slot with the smallest count. Among equal counts, the lowest index is chosen. The new slot's count is 1.
- R5: Counts are CNT_W=16 bits wide and never hold 2^16-1. When an increment would produce that value, every slot's count is shifted right by one in the same update. The incremented slot takes (old+1)>>1.
- R6: With `clr` high at a clock edge, every slot becomes unused with zero head, tail and count. Any loop event presented in that cycle or in the cycle before is discarded.
- R7: When `rd_en` is high at an edge, `q_used`/`q_head`/`q_tail`/`q_hits` show slot `rd_idx` as it stood before any table update at that same edge. While `rd_en` is low, these outputs hold their value.
- R8: After reset, all slots are unused with zero fields, and the readout outputs are zero. An unused slot always has a zero count.
- R9: A loop occupies at most one slot. Repeated passes around a loop never create a second slot for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous table clear |
| fetch_valid | input | 1 | Fetch cycle strobe |
| fetch_addr | input | 32 | Address of the fetched instruction |
| br_taken | input | 1 | Fetched instruction is a taken branch |
| br_target | input | 32 | Target of the taken branch |
| rd_en | input | 1 | Readout request |
| rd_idx | input | 4 | Slot index to read |
| q_used | output | 1 | Slot in use |
| q_head | output | 32 | Loop start address |
| q_tail | output | 32 | Loop end (branch) address |
| q_hits | output | 16 | Relative pass count |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a readout of a slot and an update of that same slot. The bench provokes it by timing a readout request so that it is sampled at the edge where a repeat pass of that slot's loop lands. The returned count must be the count from before the increment.

The second pair is a clear and loop events. The bench drives one event the cycle before `clr` and a second event together with `clr`. It then requires every slot to read back empty. The saturating increment is judged the same way: one pass makes all four live counters halve together, and each is compared against its own arithmetically halved value.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int LP_AW = 32;
    localparam int LP_CW = 16;
    localparam int LP_N  = 16;
    localparam int LP_IW = $clog2(LP_N);

    localparam logic [LP_CW-1:0] LP_CNT_TOP = '1;

    typedef struct packed {
        logic [LP_AW-1:0] head;
        logic [LP_AW-1:0] tail;
    } lp_loop_t;

    typedef struct packed {
        logic             used;
        lp_loop_t         span;
        logic [LP_CW-1:0] hits;
    } lp_slot_t;

    function automatic logic lp_is_backward(input logic [LP_AW-1:0] tgt,
                                            input logic [LP_AW-1:0] src);
        return tgt < src;
    endfunction

    function automatic logic [LP_CW-1:0] lp_halve(input logic [LP_CW-1:0] v);
        return v >> 1;
    endfunction

endpackage

// File: rtl/lp_loop_detect.sv
module lp_loop_detect
    import lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             fetch_valid,
    input  logic [LP_AW-1:0] fetch_addr,
    input  logic             br_taken,
    input  logic [LP_AW-1:0] br_target,
    output logic             ev_vld,
    output lp_loop_t         ev_loop
);

    logic seen;

    always_comb begin
        seen = fetch_valid && br_taken && lp_is_backward(br_target, fetch_addr);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ev_vld  <= 1'b0;
            ev_loop <= '0;
        end else begin
            ev_vld <= seen;
            if (seen) begin
                ev_loop.head <= br_target;
                ev_loop.tail <= fetch_addr;
            end
        end
    end

    AST_NO_EVENT_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> !ev_vld); // R6

endmodule

// File: rtl/lp_victim_sel.sv
module lp_victim_sel
    import lp_pkg::*;
(
    input  lp_slot_t [LP_N-1:0] slots,
    output logic                free_ok,
    output logic [LP_IW-1:0]    free_idx,
    output logic [LP_IW-1:0]    min_idx
);

    logic [LP_CW-1:0] min_val;

    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = LP_N - 1; i >= 0; i--) begin
            if (!slots[i].used) begin
                free_ok  = 1'b1;
                free_idx = LP_IW'(i);
            end
        end
    end

    always_comb begin
        min_idx = '0;
        min_val = slots[0].hits;
        for (int i = 1; i < LP_N; i++) begin
            if (slots[i].hits < min_val) begin
                min_val = slots[i].hits;
                min_idx = LP_IW'(i);
            end
        end
    end

endmodule

// File: rtl/lp_loop_table.sv
module lp_loop_table
    import lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ev_vld,
    input  lp_loop_t         ev_loop,
    input  logic [LP_IW-1:0] rd_idx,
    output lp_slot_t         rd_slot
);

    lp_slot_t [LP_N-1:0] slots_q;
    lp_slot_t [LP_N-1:0] slots_d;
    logic     [LP_N-1:0] hit_vec;
    logic     [LP_N-1:0] used_vec;
    logic [LP_IW-1:0]    hit_idx;
    logic [LP_IW-1:0]    free_idx;
    logic [LP_IW-1:0]    min_idx;
    logic [LP_IW-1:0]    put_idx;
    logic                free_ok;
    logic [LP_CW-1:0]    bumped;
    logic                any_top;
    logic                dirty_free;

    genvar g;
    generate
        for (g = 0; g < LP_N; g++) begin : g_match
            assign hit_vec[g]  = slots_q[g].used && (slots_q[g].span == ev_loop);
            assign used_vec[g] = slots_q[g].used;
        end
    endgenerate

    lp_victim_sel u_victim (
        .slots    (slots_q),
        .free_ok  (free_ok),
        .free_idx (free_idx),
        .min_idx  (min_idx)
    );

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < LP_N; i++) begin
            if (hit_vec[i]) hit_idx = LP_IW'(i);
        end
    end

    always_comb begin
        slots_d = slots_q;
        bumped  = slots_q[hit_idx].hits + 1'b1;
        put_idx = free_ok ? free_idx : min_idx;
        if (ev_vld) begin
            if (|hit_vec) begin
                if (bumped == LP_CNT_TOP) begin
                    for (int i = 0; i < LP_N; i++) begin
                        slots_d[i].hits = lp_halve(slots_q[i].hits);
                    end
                    slots_d[hit_idx].hits = lp_halve(bumped);
                end else begin
                    slots_d[hit_idx].hits = bumped;
                end
            end else begin
                slots_d[put_idx].used = 1'b1;
                slots_d[put_idx].span = ev_loop;
                slots_d[put_idx].hits = LP_CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slots_q <= '0;
        end else begin
            slots_q <= slots_d;
        end
    end

    assign rd_slot = slots_q[rd_idx];

    always_comb begin
        any_top    = 1'b0;
        dirty_free = 1'b0;
        for (int i = 0; i < LP_N; i++) begin
            if (slots_q[i].hits == LP_CNT_TOP) any_top = 1'b1;
            if (!slots_q[i].used && (slots_q[i].hits != '0)) dirty_free = 1'b1;
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)); // R9
    AST_COUNT_BELOW_TOP: assert property (@(posedge clk) disable iff (rst)
        !any_top); // R5
    AST_FREE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dirty_free); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (used_vec == '0)); // R6

endmodule

// File: rtl/lp_profiler.sv
module lp_profiler
    import lp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             fetch_valid,
    input  logic [LP_AW-1:0] fetch_addr,
    input  logic             br_taken,
    input  logic [LP_AW-1:0] br_target,
    input  logic             rd_en,
    input  logic [LP_IW-1:0] rd_idx,
    output logic             q_used,
    output logic [LP_AW-1:0] q_head,
    output logic [LP_AW-1:0] q_tail,
    output logic [LP_CW-1:0] q_hits
);

    logic     ev_vld;
    lp_loop_t ev_loop;
    lp_slot_t rd_slot;
    lp_slot_t q_slot;

    lp_loop_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .br_taken    (br_taken),
        .br_target   (br_target),
        .ev_vld      (ev_vld),
        .ev_loop     (ev_loop)
    );

    lp_loop_table u_table (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .ev_vld  (ev_vld),
        .ev_loop (ev_loop),
        .rd_idx  (rd_idx),
        .rd_slot (rd_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_slot <= '0;
        end else if (rd_en) begin
            q_slot <= rd_slot;
        end
    end

    assign q_used = q_slot.used;
    assign q_head = q_slot.span.head;
    assign q_tail = q_slot.span.tail;
    assign q_hits = q_slot.hits;

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(q_slot)); // R7

endmodule

// File: tb/lp_profiler_bench.sv
module lp_profiler_bench;
    import lp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        br_taken = 1'b0;
    logic [31:0] br_target = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic        q_used;
    logic [31:0] q_head;
    logic [31:0] q_tail;
    logic [15:0] q_hits;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic        m_used [16];
    logic [31:0] m_head [16];
    logic [31:0] m_tail [16];
    logic [15:0] m_hits [16];

    always #4 clk = ~clk;

    lp_profiler u_lp_profiler (
        .clk (clk), .rst (rst), .clr (clr),
        .fetch_valid (fetch_valid), .fetch_addr (fetch_addr),
        .br_taken (br_taken), .br_target (br_target),
        .rd_en (rd_en), .rd_idx (rd_idx),
        .q_used (q_used), .q_head (q_head), .q_tail (q_tail), .q_hits (q_hits)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < 16; i++) begin
            m_used[i] = 1'b0; m_head[i] = '0; m_tail[i] = '0; m_hits[i] = '0;
        end
    endtask

    task automatic m_apply(input logic [31:0] h, input logic [31:0] t);
        int hit = -1;
        int put = -1;
        logic [15:0] nv;
        for (int i = 0; i < 16; i++)
            if (m_used[i] && m_head[i] == h && m_tail[i] == t) hit = i;
        if (hit >= 0) begin
            nv = m_hits[hit] + 16'd1;
            if (nv == 16'hFFFF) begin
                for (int i = 0; i < 16; i++) m_hits[i] = m_hits[i] >> 1;
                m_hits[hit] = nv >> 1;
            end else begin
                m_hits[hit] = nv;
            end
        end else begin
            for (int i = 15; i >= 0; i--) if (!m_used[i]) put = i;
            if (put < 0) begin
                put = 0;
                for (int i = 1; i < 16; i++) if (m_hits[i] < m_hits[put]) put = i;
            end
            m_used[put] = 1'b1; m_head[put] = h; m_tail[put] = t; m_hits[put] = 16'd1;
        end
    endtask

    function automatic logic [31:0] lh(input int i);
        return 32'h1000 + i * 64;
    endfunction

    task automatic ev(input logic [31:0] tgt, input logic [31:0] adr,
                      input bit fv, input bit tk, input bit mdl);
        @(negedge clk);
        fetch_valid = fv; br_taken = tk; br_target = tgt; fetch_addr = adr;
        if (mdl && fv && tk && (tgt < adr)) m_apply(tgt, adr);
    endtask

    task automatic lp(input int i, input int n);
        repeat (n) ev(lh(i), lh(i) + 32, 1'b1, 1'b1, 1'b1);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            fetch_valid = 1'b0; br_taken = 1'b0; rd_en = 1'b0; clr = 1'b0;
        end
    endtask

    task automatic rd_chk(input int idx, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = idx[3:0];
        @(negedge clk);
        rd_en = 1'b0;
        chk({q_used, q_head, q_tail, q_hits} === {m_used[idx], m_head[idx], m_tail[idx], m_hits[idx]},
            $sformatf("%s slot %0d", tag, idx),
            {47'd0, q_used, q_head, q_tail, q_hits},
            {47'd0, m_used[idx], m_head[idx], m_tail[idx], m_hits[idx]});
    endtask

    task automatic check_all(input string tag);
        idle(2);
        for (int i = 0; i < 16; i++) rd_chk(i, tag);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 180000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=%0d expected=<180000", cycles);
                $display("test done: total=%0d bad=%0d", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int cnt;
        logic [15:0] old;
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: readout outputs zero out of reset, table empty
        chk({q_used, q_head, q_tail, q_hits} == '0, "R8 readout after reset",
            {47'd0, q_used, q_head, q_tail, q_hits}, 128'd0);
        check_all("R8");

        // R1: first sightings fill lowest free slots
        lp(0, 1); lp(1, 1); lp(2, 1);
        check_all("R1");

        // R2: ignored patterns
        ev(lh(3), lh(3) + 32, 1'b0, 1'b1, 1'b1);
        ev(lh(3), lh(3) + 32, 1'b1, 1'b0, 1'b1);
        ev(lh(3) + 32, lh(3), 1'b1, 1'b1, 1'b1);
        ev(lh(3), lh(3), 1'b1, 1'b1, 1'b1);
        check_all("R2");

        // R3: repeat passes
        lp(1, 2); lp(2, 1);
        check_all("R3");
        // R9: loop 1 has exactly one slot
        cnt = 0;
        for (int i = 0; i < 16; i++) begin
            rd_chk(i, "R9");
            if (q_used && q_head == lh(1) && q_tail == lh(1) + 32) cnt++;
        end
        chk(cnt == 1, "R9 single slot for loop", cnt, 1);

        // fill remaining slots, counts 1..4
        for (int i = 3; i < 16; i++) lp(i, ((i * 5) % 4) + 1);
        check_all("R4 fill");
        // R4: misses on a full table evict smallest, lowest index
        lp(20, 1);
        check_all("R4 evict1");
        lp(21, 1);
        check_all("R4 evict2");
        lp(22, 2);
        check_all("R4 evict3");

        // R7: read slot 1 at the edge its count changes -> old value
        idle(2);
        old = m_hits[1];
        ev(lh(1), lh(1) + 32, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        fetch_valid = 1'b0; br_taken = 1'b0; rd_en = 1'b1; rd_idx = 4'd1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(q_hits == old, "R7 same-edge read gives pre-update count", q_hits, old);
        m_apply(lh(1), lh(1) + 32);
        lp(1, 2);
        idle(3);
        chk(q_hits == old, "R7 outputs hold without rd_en", q_hits, old);
        check_all("R7");

        // R6: events before and with clear are dropped
        ev(lh(30), lh(30) + 32, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        clr = 1'b1; fetch_valid = 1'b1; br_taken = 1'b1;
        br_target = lh(31); fetch_addr = lh(31) + 32;
        m_clear();
        check_all("R6");
        lp(7, 1);
        check_all("R6 after clear");

        // R5: saturation halves all counters together
        idle(1); clr = 1'b1; m_clear(); idle(1);
        lp(0, 1); lp(1, 5); lp(2, 1); lp(3, 2);
        lp(0, 65533);
        check_all("R5 before top");
        lp(0, 1);
        check_all("R5 halved");
        chk(m_hits[0] == 16'd32767, "R5 expected halved value", m_hits[0], 16'd32767);
        lp(0, 1); lp(2, 1); lp(9, 1);
        check_all("R5 after halving");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule